// File: doc/BRIEF.md
# SCL Clock Waveform Divider

This block times the serial clock of a two-wire bus controller. It splits each SCL period into a low phase and a high phase. The length of each phase comes from its own 8-bit divisor, scaled by a shared power-of-two prescale and extended by a fixed pipeline offset set at build time. The block drives SCL as an open-drain line: `scl_out` low pulls the line down, and `scl_out` high releases it. It watches the line through `scl_in`, so a slave that holds SCL low lengthens the low phase. The high phase is timed only from the moment the line is seen high.

The byte engine uses the block as its time base. It raises `run` to start clocking and drops it to stop. Four one-cycle quarter ticks per period, each tagged with a 2-bit index, tell the engine where to change SDA and where to sample SDA. While `run` is low, the line is released and no tick is issued. Every rise of `run` starts a fresh low phase.

Top module: `scl_wave_div`

## Requirements
- R1: During reset, and afterwards while `run` is low, `scl_out` is 1 and `qtick` is 0.
- R2: `cfg_word` holds the prescale exponent in bits 18:16, the high-phase divisor in bits 15:8 and the low-phase divisor in bits 7:0.
- R3: A low phase keeps `scl_out` at 0 for exactly (low divisor << e) + OFFSET cycles, where e is the effective exponent.
- R4: A high phase lasts (high divisor << e) + OFFSET cycles. It is counted from the first cycle in which `scl_in` is high, and it ends when `scl_out` returns to 0. With no stretching, this equals the time `scl_out` is high.
- R5: An exponent field above EXP_MAX (default 5) is used as EXP_MAX.
- R6: After `scl_out` is released, while `scl_in` stays low, `scl_out` stays 1, no tick is issued and the high phase does not advance.
- R7: Take position 0 as the first cycle of a phase, and let L and H be the low-phase and high-phase lengths in cycles. Quarter ticks then come at these positions:
  - index 0 at low position 0;
  - index 1 at low position ceil(L/2);
  - index 2 at position 1 of the line-high time;
  - index 3 at high position ceil(H/2).

  No other tick is issued.
- R8: One cycle after `run` is sampled low, in any phase, `scl_out` is 1 and `qtick` is 0. One cycle after `run` is sampled high from idle, `scl_out` is 0 with a tick of index 0, and a full-length low phase begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Engine active; 0 parks the divider with SCL released |
| cfg_word | input | 19 | Waveform setting: exponent, high divisor, low divisor |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_out | output | 1 | 0 pulls SCL low, 1 releases it |
| qtick | output | 1 | One-cycle quarter-period strobe |
| qtick_idx | output | 2 | Quarter number of the current strobe (0 to 3) |

## Verification
A wrong phase counter shows up directly at `scl_out`: the low or high time comes out one or more cycles long or short, and the error appears at the end of the first phase it affects. A wrong mid-phase comparison or a wrong tick index shows up as a strobe at the wrong position, or with the wrong tag, within the same phase. A broken rise check shows up when the bench holds the line low: high-phase ticks come early, or `scl_out` drops while the line is still held. A decode or clamp fault turns every phase length from a known setting into a different number.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;
    // Phase of the SCL waveform
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;
endpackage

// File: rtl/scl_cfg_decode.sv
`timescale 1ns/1ps
module scl_cfg_decode #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int EXP_MAX = 5,
    parameter int OFFSET  = 3,
    parameter int CNT_W   = 14
) (
    input  logic [EXP_W+2*DIV_W-1:0] cfg_word,
    output logic [CNT_W-1:0]         low_len,
    output logic [CNT_W-1:0]         high_len
);
    localparam int CFG_W = EXP_W + 2 * DIV_W;

    logic [EXP_W-1:0] exp_raw;
    logic [EXP_W-1:0] exp_eff;
    logic [DIV_W-1:0] div_hi;
    logic [DIV_W-1:0] div_lo;

    assign exp_raw = cfg_word[CFG_W-1 -: EXP_W];
    assign div_hi  = cfg_word[2*DIV_W-1 -: DIV_W];
    assign div_lo  = cfg_word[DIV_W-1:0];

    // Clamp only when the field can exceed the implementation maximum
    if (EXP_MAX >= (1 << EXP_W) - 1) begin : g_noclamp
        assign exp_eff = exp_raw;
    end else begin : g_clamp
        assign exp_eff = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;
    end

    always_comb begin
        low_len  = (CNT_W'(div_lo) << exp_eff) + CNT_W'(OFFSET);
        high_len = (CNT_W'(div_hi) << exp_eff) + CNT_W'(OFFSET);
    end
endmodule

// File: rtl/scl_phase_ctl.sv
`timescale 1ns/1ps
module scl_phase_ctl
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             scl_out,
    output logic             qtick,
    output logic [1:0]       qtick_idx
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             tick;
        logic [1:0]       idx;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [CNT_W-1:0] half_lo, half_hi;

    assign half_lo = low_len >> 1;
    assign half_hi = high_len >> 1;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!run) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.scl = 1'b1;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph   = PH_LOW;
                    st_d.cnt  = low_len - CNT_W'(1);
                    st_d.scl  = 1'b0;
                    st_d.tick = 1'b1;
                    st_d.idx  = 2'd0;
                end
                PH_LOW: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_WAIT;
                        st_d.scl = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                        if (st_q.cnt == half_lo) begin
                            st_d.tick = 1'b1;
                            st_d.idx  = 2'd1;
                        end
                    end
                end
                PH_WAIT: begin
                    // the line-high cycle seen here is the first of the high phase
                    if (scl_in) begin
                        st_d.ph   = PH_HIGH;
                        st_d.cnt  = high_len - CNT_W'(2);
                        st_d.tick = 1'b1;
                        st_d.idx  = 2'd2;
                    end
                end
                PH_HIGH: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph   = PH_LOW;
                        st_d.cnt  = low_len - CNT_W'(1);
                        st_d.scl  = 1'b0;
                        st_d.tick = 1'b1;
                        st_d.idx  = 2'd0;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                        if (st_q.cnt == half_hi) begin
                            st_d.tick = 1'b1;
                            st_d.idx  = 2'd3;
                        end
                    end
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.scl  <= 1'b1;
            st_q.tick <= 1'b0;
            st_q.idx  <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_out   = st_q.scl;
    assign qtick     = st_q.tick;
    assign qtick_idx = st_q.idx;

    // R8: dropping run parks the line released and silent
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.scl && !st_q.tick));

    // R3: the low phase counts down one per cycle with the line held low
    p_low_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LOW && run && st_q.cnt != '0) |=>
            (st_q.cnt == $past(st_q.cnt) - CNT_W'(1) && !st_q.scl));

    // R6: a held line freezes the divider in the released state
    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_WAIT && run && !scl_in) |=>
            (st_q.ph == PH_WAIT && st_q.scl && !st_q.tick));

    // R7: every falling SCL carries the quarter-zero tick
    p_fall_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.scl) |-> (st_q.tick && st_q.idx == 2'd0));
endmodule

// File: rtl/scl_wave_div.sv
`timescale 1ns/1ps
module scl_wave_div #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int EXP_MAX = 5,
    parameter int OFFSET  = 3   // at least 3 so every phase holds its quarter ticks
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [EXP_W+2*DIV_W-1:0] cfg_word,
    input  logic                     scl_in,
    output logic                     scl_out,
    output logic                     qtick,
    output logic [1:0]               qtick_idx
);
    localparam int CNT_W = DIV_W + EXP_MAX + 2;

    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;

    scl_cfg_decode #(
        .DIV_W  (DIV_W),
        .EXP_W  (EXP_W),
        .EXP_MAX(EXP_MAX),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) i_cfg (
        .cfg_word(cfg_word),
        .low_len (low_len),
        .high_len(high_len)
    );

    scl_phase_ctl #(
        .CNT_W(CNT_W)
    ) i_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .scl_in   (scl_in),
        .low_len  (low_len),
        .high_len (high_len),
        .scl_out  (scl_out),
        .qtick    (qtick),
        .qtick_idx(qtick_idx)
    );
endmodule

// File: tb/test_scl_wave_div.sv
`timescale 1ns/1ps
module test_scl_wave_div;
    localparam int EXP_MAX = 5;
    localparam int OFFSET  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        hold = 1'b0;
    logic [18:0] cfg = '0;
    logic        scl_out, qtick;
    logic [1:0]  qtick_idx;
    logic        scl_in;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    assign scl_in = scl_out & ~hold;   // open-drain line with an optional slave hold

    scl_wave_div i_scl_wave_div (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg),
        .scl_in(scl_in), .scl_out(scl_out), .qtick(qtick), .qtick_idx(qtick_idx)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 190000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    function automatic int exp_len(int dv, int e);
        int ee = (e > EXP_MAX) ? EXP_MAX : e;
        return (dv << ee) + OFFSET;
    endfunction

    function automatic int tick_now();
        return qtick ? int'(qtick_idx) : -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // entry: current sample is low position 0
    task automatic do_low(input int L, input int S);
        int pos = 0;
        int ex;
        hold = (S > 0);
        while (scl_out == 1'b0 && pos < L + 8) begin
            ex = (pos == 0) ? 0 : (pos == (L + 1) / 2) ? 1 : -1;
            chk(tick_now() == ex, "R7 low-phase tick", tick_now(), ex);
            pos++;
            @(negedge clk);
        end
        chk(pos == L, "R3 low length", pos, L);
    endtask

    // entry: first sample with scl_out released
    task automatic do_high(input int H, input int S);
        int pos = 0;
        int ex;
        for (int i = 0; i < S; i++) begin
            chk(scl_out == 1'b1 && !qtick, "R6 stretch holds", {30'd0, scl_out, qtick}, 2);
            @(negedge clk);
        end
        hold = 1'b0;
        while (scl_out == 1'b1 && pos < H + 8) begin
            ex = (pos == 1) ? 2 : (pos == (H + 1) / 2) ? 3 : -1;
            chk(tick_now() == ex, "R7 high-phase tick", tick_now(), ex);
            pos++;
            @(negedge clk);
        end
        chk(pos == H, "R4 high length", pos, H);
    endtask

    task automatic run_cfg(input int e, input int hi, input int lo, input int nper, input int S);
        int L = exp_len(lo, e);
        int H = exp_len(hi, e);
        cfg = {e[2:0], hi[7:0], lo[7:0]};
        run = 1'b1;
        hold = (S > 0);
        @(negedge clk);
        chk(scl_out == 1'b0 && tick_now() == 0, "R8 start", tick_now(), 0);
        for (int p = 0; p < nper; p++) begin
            do_low(L, S);
            do_high(H, S);
        end
        chk(scl_out == 1'b0 && tick_now() == 0, "R7 next fall tick", tick_now(), 0);
        run = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1 && !qtick, "R8 stop releases", {30'd0, scl_out, qtick}, 2);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(scl_out == 1'b1 && !qtick, "R1 in reset", {30'd0, scl_out, qtick}, 2);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(scl_out == 1'b1 && !qtick, "R1 idle after reset", {30'd0, scl_out, qtick}, 2);
        end

        // R2: distinct fields; swapping them would change both lengths
        run_cfg(1, 9, 5, 2, 0);
        // minimum lengths (divisors zero)
        run_cfg(0, 0, 0, 3, 0);
        // R5: exponent above the maximum is clamped
        run_cfg(7, 2, 1, 1, 0);
        run_cfg(6, 1, 3, 1, 0);
        run_cfg(5, 1, 1, 1, 0);
        // R6: slave stretching
        run_cfg(0, 6, 4, 2, 5);
        run_cfg(2, 3, 7, 1, 1);

        // R8: drop during low, then a clean restart
        cfg = {3'd1, 8'd4, 8'd6};
        run = 1'b1;
        repeat (6) @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(scl_out == 1'b1 && !qtick, "R8 drop in low", {30'd0, scl_out, qtick}, 2);
        end
        run_cfg(1, 4, 6, 1, 0);

        // R8: drop during high
        cfg = {3'd0, 8'd20, 8'd2};
        run = 1'b1;
        @(negedge clk);
        do_low(exp_len(2, 0), 0);
        repeat (4) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1 && !qtick, "R8 drop in high", {30'd0, scl_out, qtick}, 2);
        @(negedge clk);

        // random settings
        for (int t = 0; t < 12; t++) begin
            int e  = $urandom % 8;
            int hi = (e > 2) ? ($urandom % 32) : ($urandom % 256);
            int lo = (e > 2) ? ($urandom % 32) : ($urandom % 256);
            int s  = ($urandom % 3 == 0) ? ($urandom % 6) : 0;
            run_cfg(e, hi, lo, 2, s);
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule